// File: doc/BRIEF.md
# Serial Command Slave Front End

This block is the slave side of a select-plus-three-wire serial memory link. It oversamples the select, serial clock and serial data pins in a faster system clock, finds the start bit of each command, and collects a 2-bit opcode, an 8-bit address and, for the two data-carrying commands, a 16-bit data word. Each finished frame is handed to the control logic as a one-clock strobe with its fields and the two mode pin levels. A separate strobe marks the falling select edge that should launch execution of a complete frame.

For read commands the block fetches words from a 256-entry memory port and serialises them on the output pin. As long as the host keeps clocking, the address advances by one per word and wraps from the top word back to word 0. A read aimed at the protect register (mode pin high) returns an 8-bit value instead. Protection policy, the array and program timing live behind the request and response ports.

The parser FSM has the states RX_IDLE (deselected), RX_HUNT (waiting for a 1), RX_OPCODE, RX_ADDR, RX_DATA, RX_ARMED (complete, waiting for select to drop), RX_STREAM (read in progress) and RX_SPOIL (extra clock after completion). Its transitions are: RX_IDLE to RX_HUNT on select high; RX_HUNT to RX_OPCODE on a sampled 1; RX_OPCODE to RX_ADDR after two bits; RX_ADDR to RX_STREAM, RX_DATA or RX_ARMED after eight bits; RX_DATA to RX_ARMED after sixteen bits; RX_ARMED to RX_SPOIL on any further clock edge; any state to RX_IDLE when select is low. The output FSM has TX_OFF, TX_DUMMY (lead-in zero), TX_WORD (shifting) and TX_TAIL (protect value sent, zeros follow). Its transitions are: TX_OFF to TX_DUMMY on a read start; TX_DUMMY to TX_WORD on the next clock edge; TX_WORD to TX_TAIL after the last protect bit; any state to TX_OFF when select is low.

Top module: `mwire_slave`

## Requirements
- R1: While select is low, serial clock and data edges produce no frame strobe and no memory request. Dropping select in the middle of a frame discards the partial frame, and the next frame after select rises is parsed from its own start bit.
- R2: Zero bits sampled before the start bit are skipped, and the first 1 sampled after select rises is taken as the start bit.
- R3: The two bits after the start bit form the opcode and the next eight the address, MSB first. For a frame with no data field, frame_valid pulses for one clock after the last address bit, carrying opcode, address, frame_data = 0 and the PRE/PE pin levels sampled at that bit.
- R4: A data field of 16 bits, D15 first, follows the address only when PRE is 0 and either the opcode is 01 or the opcode is 00 with address bits [7:6] = 01. frame_valid then pulses after D0 and carries the data. Opcode 01 with PRE = 1 has no data field and strobes after the address.
- R5: frame_commit pulses once when select falls after a complete non-read frame, provided no serial clock rising edge came after the frame's last bit. Such an extra edge cancels the commit.
- R6: A read (opcode 10, PRE = 0) enables do_o at the rising edge that samples the last address bit and drives a single 0 there. The 16 data bits of the addressed word then follow, MSB first, one per rising edge.
- R7: When clocking continues past a word's D0, the word at the next address follows with no lead-in zero, and address 0xFF is followed by 0x00. One memory request is issued per word: the first at the last address bit, and each later one at the edge that drives D0 of the current word.
- R8: A read with PRE = 1 drives a 0, then prot_val[7:0] MSB first, then zeros until select falls. It issues no memory request.
- R9: do_oe is 0 and do_o is 0 outside a read and within a few system clocks after select goes low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select from the host, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| pre_i | input | 1 | Mode pin: 1 selects protect-register commands |
| pe_i | input | 1 | Program enable pin level |
| do_o | output | 1 | Serial data to the host |
| do_oe | output | 1 | Output enable for do_o (high-impedance when 0) |
| frame_valid | output | 1 | One-clock strobe for a parsed frame |
| frame_op | output | 2 | Opcode of the frame |
| frame_addr | output | 8 | Address of the frame |
| frame_data | output | 16 | Data word, 0 when the frame has none |
| frame_pre | output | 1 | PRE level at the frame's last bit |
| frame_pe | output | 1 | PE level at the frame's last bit |
| frame_commit | output | 1 | Strobe on select fall after a complete non-read frame |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 8 | Memory read address |
| mem_rd_data | input | 16 | Read data, valid the clock after the request |
| prot_val | input | 8 | Current protect register value |

## Verification
The hardest situation to reach is the read stream crossing the top of the address space. Here the prefetch for the next word must be issued at D0 and land before the following edge, and the address counter must wrap. The stimulus starts a read at 0xFE and keeps the serial clock running for three full words, so the wrap to 0x00 is both heard on do_o and seen in the request addresses. The cancelled commit is reached by clocking one extra bit after a complete control frame before select drops.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HUNT,
        RX_OPCODE,
        RX_ADDR,
        RX_DATA,
        RX_ARMED,
        RX_STREAM,
        RX_SPOIL
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_DUMMY,
        TX_WORD,
        TX_TAIL
    } tx_state_e;

    localparam logic [1:0] OP_MISC   = 2'b00;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] FILL_SEL  = 2'b01;

endpackage

// File: rtl/mwire_sync.sv
module mwire_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= '0;
            end else if (s == 0) begin
                pipe[s] <= async_i;
            end else begin
                pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/mwire_frame_rx.sv
module mwire_frame_rx
    import mwire_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              di_s,
    input  logic              pre_s,
    input  logic              pe_s,
    output logic              frame_valid,
    output logic [1:0]        frame_op,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_pre,
    output logic              frame_pe,
    output logic              frame_commit,
    output logic              rd_start,
    output logic              rd_prot
);
    localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXW);

    rx_state_e         state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q, addr_shift;
    logic [DATA_W-1:0] data_q, data_shift;
    logic              wants_data, is_read;
    logic              op_last, addr_last, data_last;

    always_comb begin
        addr_shift = {addr_q[ADDR_W-2:0], di_s};
        data_shift = {data_q[DATA_W-2:0], di_s};
        is_read    = (op_q == OP_READ);
        wants_data = !pre_s && ((op_q == OP_WRITE) ||
                     ((op_q == OP_MISC) && (addr_shift[ADDR_W-1 -: 2] == FILL_SEL)));
        op_last    = sk_rise && (cnt == CNT_W'(1));
        addr_last  = sk_rise && (cnt == CNT_W'(ADDR_W-1));
        data_last  = sk_rise && (cnt == CNT_W'(DATA_W-1));
        state_nxt  = state;
        unique case (state)
            RX_IDLE:   if (cs_s) state_nxt = RX_HUNT;
            RX_HUNT:   if (sk_rise && di_s) state_nxt = RX_OPCODE;
            RX_OPCODE: if (op_last) state_nxt = RX_ADDR;
            RX_ADDR:   if (addr_last) state_nxt = is_read ? RX_STREAM :
                                                 (wants_data ? RX_DATA : RX_ARMED);
            RX_DATA:   if (data_last) state_nxt = RX_ARMED;
            RX_ARMED:  if (sk_rise) state_nxt = RX_SPOIL;
            RX_STREAM: state_nxt = RX_STREAM;
            RX_SPOIL:  state_nxt = RX_SPOIL;
        endcase
        if (!cs_s) state_nxt = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            op_q         <= '0;
            addr_q       <= '0;
            data_q       <= '0;
            frame_valid  <= 1'b0;
            frame_op     <= '0;
            frame_addr   <= '0;
            frame_data   <= '0;
            frame_pre    <= 1'b0;
            frame_pe     <= 1'b0;
            frame_commit <= 1'b0;
            rd_start     <= 1'b0;
            rd_prot      <= 1'b0;
        end else begin
            frame_valid  <= 1'b0;
            rd_start     <= 1'b0;
            frame_commit <= (state == RX_ARMED) && !cs_s;
            if (!cs_s || state == RX_HUNT || state == RX_IDLE) begin
                cnt    <= '0;
                op_q   <= '0;
                addr_q <= '0;
                data_q <= '0;
            end else if (sk_rise) begin
                unique case (state)
                    RX_OPCODE: begin
                        op_q <= {op_q[0], di_s};
                        cnt  <= op_last ? '0 : cnt + 1'b1;
                    end
                    RX_ADDR: begin
                        addr_q <= addr_shift;
                        cnt    <= addr_last ? '0 : cnt + 1'b1;
                        if (addr_last && !(wants_data && !is_read)) begin
                            frame_valid <= 1'b1;
                            frame_op    <= op_q;
                            frame_addr  <= addr_shift;
                            frame_data  <= '0;
                            frame_pre   <= pre_s;
                            frame_pe    <= pe_s;
                            rd_start    <= is_read;
                            rd_prot     <= pre_s;
                        end
                    end
                    RX_DATA: begin
                        data_q <= data_shift;
                        cnt    <= data_last ? '0 : cnt + 1'b1;
                        if (data_last) begin
                            frame_valid <= 1'b1;
                            frame_op    <= op_q;
                            frame_addr  <= addr_q;
                            frame_data  <= data_shift;
                            frame_pre   <= pre_s;
                            frame_pe    <= pe_s;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a frame strobe only follows a sampled serial clock edge
    a_r3_valid_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(sk_rise));

    // R1: nothing is parsed while deselected
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_s) |-> !frame_valid);

    // R5: commit only follows a select that has gone low
    a_r5_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        frame_commit |-> !$past(cs_s));
endmodule

// File: rtl/mwire_read_tx.sv
module mwire_read_tx
    import mwire_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              rd_start,
    input  logic              rd_prot,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [PROT_W-1:0] prot_val,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              do_o,
    output logic              do_oe
);
    localparam int BW = $clog2(DATA_W);

    tx_state_e         state, state_nxt;
    logic [DATA_W-1:0] shreg, word_buf;
    logic [ADDR_W-1:0] ptr;
    logic [BW-1:0]     bitcnt;
    logic              prot_mode, rd_pend, word_end;

    always_comb begin
        word_end  = (bitcnt == (prot_mode ? BW'(PROT_W-1) : BW'(DATA_W-1)));
        state_nxt = state;
        unique case (state)
            TX_OFF:   if (rd_start) state_nxt = TX_DUMMY;
            TX_DUMMY: if (sk_rise) state_nxt = TX_WORD;
            TX_WORD:  if (sk_rise && word_end && prot_mode) state_nxt = TX_TAIL;
            TX_TAIL:  state_nxt = TX_TAIL;
        endcase
        if (!cs_s) state_nxt = TX_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            word_buf    <= '0;
            ptr         <= '0;
            bitcnt      <= '0;
            prot_mode   <= 1'b0;
            rd_pend     <= 1'b0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            do_o        <= 1'b0;
            do_oe       <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            rd_pend   <= mem_rd_en;
            if (rd_pend) word_buf <= mem_rd_data;
            if (!cs_s) begin
                do_o   <= 1'b0;
                do_oe  <= 1'b0;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    TX_OFF: if (rd_start) begin
                        do_oe     <= 1'b1;
                        do_o      <= 1'b0;
                        ptr       <= start_addr;
                        prot_mode <= rd_prot;
                        if (rd_prot) begin
                            word_buf <= DATA_W'(prot_val) << (DATA_W - PROT_W);
                        end else begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= start_addr;
                        end
                    end
                    TX_DUMMY: if (sk_rise) begin
                        shreg  <= word_buf << 1;
                        do_o   <= word_buf[DATA_W-1];
                        bitcnt <= '0;
                    end
                    TX_WORD: if (sk_rise) begin
                        if (word_end) begin
                            if (prot_mode) begin
                                do_o <= 1'b0;
                            end else begin
                                shreg  <= word_buf << 1;
                                do_o   <= word_buf[DATA_W-1];
                                bitcnt <= '0;
                            end
                        end else begin
                            do_o   <= shreg[DATA_W-1];
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt + 1'b1;
                            if (!prot_mode && bitcnt == BW'(DATA_W-2)) begin
                                ptr         <= ptr + 1'b1;
                                mem_rd_en   <= 1'b1;
                                mem_rd_addr <= ptr + 1'b1;
                            end
                        end
                    end
                    TX_TAIL: do_o <= 1'b0;
                endcase
            end
        end
    end

    // R9: output enable drops once select is low
    a_r9_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe);

    // R6: while driving, the output only moves after a serial clock edge
    a_r6_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && $past(do_oe) && !$past(sk_rise)) |-> $stable(do_o));

    // R7: requests are single-clock strobes
    a_r7_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: protect reads never touch the memory port
    a_r8_no_mem_on_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_TAIL) |-> !mem_rd_en);
endmodule

// File: rtl/mwire_slave.sv
module mwire_slave #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    input  logic              pre_i,
    input  logic              pe_i,
    output logic              do_o,
    output logic              do_oe,
    output logic              frame_valid,
    output logic [1:0]        frame_op,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_pre,
    output logic              frame_pe,
    output logic              frame_commit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [ADDR_W-1:0] prot_val
);
    localparam int PIN_N = 5;

    logic [PIN_N-1:0] pins_s;
    logic cs_s, sk_s, di_s, pre_s, pe_s, sk_q, sk_rise;
    logic rd_start, rd_prot;

    mwire_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sk_i, di_i, pre_i, pe_i}),
        .sync_o  (pins_s)
    );

    assign {cs_s, sk_s, di_s, pre_s, pe_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_s;
    end

    assign sk_rise = sk_s && !sk_q && cs_s;

    mwire_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_s         (cs_s),
        .sk_rise      (sk_rise),
        .di_s         (di_s),
        .pre_s        (pre_s),
        .pe_s         (pe_s),
        .frame_valid  (frame_valid),
        .frame_op     (frame_op),
        .frame_addr   (frame_addr),
        .frame_data   (frame_data),
        .frame_pre    (frame_pre),
        .frame_pe     (frame_pe),
        .frame_commit (frame_commit),
        .rd_start     (rd_start),
        .rd_prot      (rd_prot)
    );

    mwire_read_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(ADDR_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sk_rise     (sk_rise),
        .rd_start    (rd_start),
        .rd_prot     (rd_prot),
        .start_addr  (frame_addr),
        .mem_rd_data (mem_rd_data),
        .prot_val    (prot_val),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .do_o        (do_o),
        .do_oe       (do_oe)
    );
endmodule

// File: tb/mwire_slave_tb.sv
module mwire_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SK    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0, pre_i = 1'b0, pe_i = 1'b0;
    logic        do_o, do_oe, frame_valid, frame_pre, frame_pe, frame_commit, mem_rd_en;
    logic [1:0]  frame_op;
    logic [7:0]  frame_addr, mem_rd_addr;
    logic [15:0] frame_data;
    logic [15:0] mem_rd_data = '0;
    logic [7:0]  prot_val = 8'hA5;

    int nchk = 0, nerr = 0, vcnt = 0, ccnt = 0, lowcnt = 0;
    bit done = 0;
    logic [1:0]  l_op;
    logic [7:0]  l_addr;
    logic [15:0] l_data;
    logic        l_pre, l_pe;
    logic [7:0]  rdq [$];
    logic [15:0] mem [256];
    logic        s_do, s_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwire_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .pre_i(pre_i), .pe_i(pe_i), .do_o(do_o), .do_oe(do_oe),
        .frame_valid(frame_valid), .frame_op(frame_op), .frame_addr(frame_addr),
        .frame_data(frame_data), .frame_pre(frame_pre), .frame_pe(frame_pe),
        .frame_commit(frame_commit), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .prot_val(prot_val)
    );

    // memory behaviour: data returns one clock after the request
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor compared on every clock
    always @(negedge clk) begin
        if (frame_valid) begin
            vcnt++; l_op = frame_op; l_addr = frame_addr; l_data = frame_data;
            l_pre = frame_pre; l_pe = frame_pe;
        end
        if (frame_commit) ccnt++;
        if (mem_rd_en) rdq.push_back(mem_rd_addr);
        if (rst_n) begin
            if (!cs_i) lowcnt++; else lowcnt = 0;
            if (lowcnt >= 4) begin
                check("R9 oe while deselected", {31'd0, do_oe}, 32'd0);
                check("R9 do while deselected", {31'd0, do_o}, 32'd0);
            end
        end
    end

    task automatic sk_cycle(input logic b);
        di_i = b;
        repeat (HALF_SK) @(negedge clk);
        s_do = do_o; s_oe = do_oe;
        sk_i = 1'b1;
        repeat (HALF_SK) @(negedge clk);
        sk_i = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_cycle(v[i]);
    endtask

    task automatic sel();
        cs_i = 1'b1;
        repeat (HALF_SK) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF_SK) @(negedge clk);
        cs_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int v0, c0, q0;
        logic [15:0] w;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        check("R9 reset oe", {31'd0, do_oe}, 0);
        check("R3 reset valid", {31'd0, frame_valid}, 0);

        // R1: activity while deselected
        v0 = vcnt; q0 = rdq.size();
        send(32'hFFFF, 16);
        check("R1 no frame while deselected", vcnt, v0);
        check("R1 no request while deselected", rdq.size(), q0);

        // R2/R3: leading zeros, control frame
        pe_i = 1'b1; c0 = ccnt; v0 = vcnt;
        sel();
        send(32'b000_1_00_11000101, 14);
        check("R9 oe off in control frame", {31'd0, s_oe}, 0);
        check("R2 one frame after leading zeros", vcnt, v0 + 1);
        check("R3 opcode", l_op, 2'b00);
        check("R3 address", l_addr, 8'hC5);
        check("R3 data zero", l_data, 0);
        check("R3 pe level", {l_pre, l_pe}, 2'b01);
        desel();
        check("R5 commit after frame", ccnt, c0 + 1);

        // R4: write with data
        v0 = vcnt; c0 = ccnt;
        sel();
        send({1'b1, 2'b01, 8'h37}, 11);
        check("R4 no strobe before data", vcnt, v0);
        send(32'hBEEF, 16);
        check("R4 write strobe", vcnt, v0 + 1);
        check("R4 write opcode", l_op, 2'b01);
        check("R4 write addr", l_addr, 8'h37);
        check("R4 write data", l_data, 16'hBEEF);
        desel();
        check("R5 commit after write", ccnt, c0 + 1);

        // R4: fill-all form (op 00, addr[7:6]=01)
        v0 = vcnt;
        sel();
        send({1'b1, 2'b00, 8'h40, 16'h1234}, 27);
        check("R4 fill strobe", vcnt, v0 + 1);
        check("R4 fill data", l_data, 16'h1234);
        desel();

        // R4: op 01 with PRE high carries no data
        pre_i = 1'b1; v0 = vcnt;
        sel();
        send({1'b1, 2'b01, 8'h80}, 11);
        check("R4 protect write strobes at address", vcnt, v0 + 1);
        check("R4 protect write no data", l_data, 0);
        check("R4 protect write pre", {31'd0, l_pre}, 1);
        desel();
        pre_i = 1'b0;

        // R5: extra edge cancels the commit
        c0 = ccnt; v0 = vcnt;
        sel();
        send({1'b1, 2'b00, 8'h05}, 11);
        sk_cycle(1'b0);
        desel();
        check("R5 frame seen", vcnt, v0 + 1);
        check("R5 extra edge cancels commit", ccnt, c0);

        // R1: partial frame discarded
        c0 = ccnt; v0 = vcnt;
        sel();
        send({1'b1, 2'b01, 3'b111}, 6);
        desel();
        check("R1 partial frame no strobe", vcnt, v0);
        check("R1 partial frame no commit", ccnt, c0);
        sel();
        send({1'b1, 2'b00, 8'hC3}, 11);
        check("R1 fresh frame parsed", vcnt, v0 + 1);
        check("R1 fresh frame addr", l_addr, 8'hC3);
        desel();

        // R6/R7: sequential read across the wrap
        q0 = rdq.size();
        sel();
        send({1'b1, 2'b10, 8'hFE}, 11);
        sk_cycle(1'b0);
        check("R6 dummy oe", {31'd0, s_oe}, 1);
        check("R6 dummy bit", {31'd0, s_do}, 0);
        for (int k = 0; k < 3; k++) begin
            w = mem[8'(8'hFE + k)];
            for (int b = 15; b >= 0; b--) begin
                sk_cycle(1'b0);
                check(k == 0 ? "R6 first word bit" : "R7 next word bit", {31'd0, s_do}, {31'd0, w[b]});
            end
        end
        desel();
        check("R7 request count", rdq.size() - q0, 4);
        check("R7 first request", rdq[q0], 8'hFE);
        check("R7 second request", rdq[q0 + 1], 8'hFF);
        check("R7 wrap request", rdq[q0 + 2], 8'h00);

        // R8: protect register read
        pre_i = 1'b1; q0 = rdq.size();
        sel();
        send({1'b1, 2'b10, 8'h00}, 11);
        sk_cycle(1'b0);
        check("R8 dummy bit", {s_oe, s_do}, 2'b10);
        for (int b = 7; b >= 0; b--) begin
            sk_cycle(1'b0);
            check("R8 protect bit", {31'd0, s_do}, {31'd0, prot_val[b]});
        end
        for (int b = 0; b < 4; b++) begin
            sk_cycle(1'b0);
            check("R8 trailing zero", {s_oe, s_do}, 2'b10);
        end
        desel();
        check("R8 no memory request", rdq.size(), q0);
        pre_i = 1'b0;
        check("R9 oe after read", {31'd0, do_oe}, 0);

        finish_run();
    end
endmodule